// File: doc/BRIEF.md
# Global Status and Error Flag Composer

This block holds the eight-bit global status byte that a serial slave returns at the head of every frame. It also holds the eight-bit configuration register that sits at RAM address 3FH. Fault events from the device (fail-safe entry, thermal shutdown or overload, temperature pre-warning and two device-specific faults) are caught in sticky bits. Two link bits follow the frame checker. A "not reset and no communication error" bit is low after power-on and rises once a valid frame has been received. A communication-error bit records a frame with a bad clock count.

The error flag in bit 7 combines every fault indication. It also takes in four external fault groups that summarise other status registers. Configuration masks can take the maskable status bits and the external groups out of the flag, while the status byte still reports those bits. The flag drives an open-drain failure line, which is modelled here as an output enable that pulls the shared line low.

The serial slave pulses `clr_i` for a read-and-clear of the global status register, and for the global clear at 3FH. It pulses `cfg_we_i` on a write to 3FH. Bit 0 of the configuration register is passed out as the watchdog trigger.

Top module: `glob_status_unit`

## Requirements
- R1: After reset the status byte reads 8'h80 (bit 5 low, so the flag is high), the configuration register reads 8'h00 and `fail_od_o` is 1.
- R2: `fault_i` index k sets status bit k on the next clock edge when feature k is present. The mapping is: bit 0 fail-safe, bit 1 device fault A, bit 2 device fault B, bit 3 temperature pre-warning, bit 4 thermal shutdown or overload.
- R3: A set fault bit stays set after its input falls, until `clr_i` is pulsed. If the input is still high in the clear cycle, the bit stays set.
- R4: A fault bit whose feature is absent (`FEAT_EN` bit 0; by default bit 2) always reads 0, whatever its input does.
- R5: Status bit 5 is 0 after reset. A `frame_ok_i` pulse sets it on the next edge, and a `comm_err_i` pulse clears it on the next edge. `clr_i` leaves it unchanged.
- R6: Status bit 6 is set by `comm_err_i` and is cleared by `frame_ok_i` or `clr_i`. When set and clear arrive in the same cycle, the set wins.
- R7: Status bit 7 is the OR of bit 0, bit 4, the unmasked bits among 3:1, bit 6, the inverse of bit 5, and the unmasked `ext_fault_i` groups. It follows `ext_fault_i` in the same cycle.
- R8: Configuration bits 3:1, when set to 1, remove status bits 3:1 from the flag. The status byte still shows those bits.
- R9: Configuration bit 4+j, when set to 1, removes `ext_fault_i[j]` from the flag.
- R10: `cfg_we_i` loads `cfg_wdata_i` on the next edge. The register holds its value otherwise, and `clr_i` does not change it. `wd_trig_o` shows configuration bit 0.
- R11: `fail_od_o` is 1 exactly when the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 5 | Fault events or levels, one per status bit 4:0 |
| ext_fault_i | input | 4 | External fault groups (ORs of other status registers) |
| comm_err_i | input | 1 | Pulse: frame rejected by the clock-count check |
| frame_ok_i | input | 1 | Pulse: valid frame completed |
| clr_i | input | 1 | Pulse: clear the global status byte |
| cfg_we_i | input | 1 | Pulse: write the configuration register |
| cfg_wdata_i | input | 8 | Configuration write data |
| status_o | output | 8 | Global status byte |
| cfg_o | output | 8 | Configuration register |
| wd_trig_o | output | 1 | Watchdog trigger bit |
| flag_o | output | 1 | Global error flag level |
| fail_od_o | output | 1 | Open-drain pull-down enable for the failure line |

## Verification
Every state bit (bits 6:0 and the configuration register) is due on the first clock edge after the input pulse that changes it. The flag and the open-drain enable change in the same cycle as the state they combine, and in the same cycle as `ext_fault_i`. The bench drives inputs on the falling edge and updates its reference model at the rising edge from those inputs. It then compares every output at the next falling edge, so a registered result is checked exactly one edge after its cause, and a combinational one is checked under the inputs that produced it.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
  localparam int STAT_W   = 8;
  localparam int CFG_W    = 8;
  localparam int FLT_N    = 5;
  localparam int EXT_N    = 4;
  localparam int BIT_LINK = 5;
  localparam int BIT_COMM = 6;
  localparam int BIT_FLAG = 7;
  // status bits that the configuration may mask out of the flag
  localparam logic [FLT_N-1:0] MASKABLE = 5'b01110;
endpackage

// File: rtl/gsu_sticky.sv
module gsu_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/gsu_link.sv
module gsu_link (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic comm_err_i,
  input  logic frame_ok_i,
  input  logic clr_i,
  output logic comm_o,
  output logic link_ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comm_o    <= 1'b0;
      link_ok_o <= 1'b0;
    end else begin
      if (comm_err_i)                comm_o <= 1'b1;
      else if (frame_ok_i || clr_i)  comm_o <= 1'b0;
      if (comm_err_i)                link_ok_o <= 1'b0;
      else if (frame_ok_i)           link_ok_o <= 1'b1;
    end
  end
endmodule

// File: rtl/gsu_cfg.sv
module gsu_cfg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/gsu_flag.sv
module gsu_flag
  import gsu_pkg::*;
(
  input  logic [FLT_N-1:0] fault_q_i,
  input  logic [FLT_N-1:0] fault_mask_i,
  input  logic             comm_i,
  input  logic             link_ok_i,
  input  logic [EXT_N-1:0] ext_i,
  input  logic [EXT_N-1:0] ext_mask_i,
  output logic             flag_o
);
  always_comb begin
    flag_o = |(fault_q_i & ~fault_mask_i) | comm_i | ~link_ok_i | |(ext_i & ~ext_mask_i);
  end
endmodule

// File: rtl/glob_status_unit.sv
module glob_status_unit
  import gsu_pkg::*;
#(
  parameter logic [FLT_N-1:0] FEAT_EN = 5'b11011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLT_N-1:0]  fault_i,
  input  logic [EXT_N-1:0]  ext_fault_i,
  input  logic              comm_err_i,
  input  logic              frame_ok_i,
  input  logic              clr_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              wd_trig_o,
  output logic              flag_o,
  output logic              fail_od_o
);
  logic [FLT_N-1:0] fault_q;
  logic [FLT_N-1:0] fault_mask;
  logic             comm_q, link_ok_q;

  for (genvar k = 0; k < FLT_N; k++) begin : g_fault
    if (FEAT_EN[k]) begin : g_on
      gsu_sticky i_bit (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (fault_i[k]),
        .clr_i (clr_i),
        .q_o   (fault_q[k])
      );
    end else begin : g_off
      assign fault_q[k] = 1'b0;
    end
    if (MASKABLE[k]) begin : g_msk
      assign fault_mask[k] = cfg_o[k];
    end else begin : g_nomsk
      assign fault_mask[k] = 1'b0;
    end
  end

  gsu_link i_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .comm_err_i(comm_err_i),
    .frame_ok_i(frame_ok_i),
    .clr_i     (clr_i),
    .comm_o    (comm_q),
    .link_ok_o (link_ok_q)
  );

  gsu_cfg #(.W(CFG_W)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .q_o    (cfg_o)
  );

  gsu_flag i_flag (
    .fault_q_i   (fault_q),
    .fault_mask_i(fault_mask),
    .comm_i      (comm_q),
    .link_ok_i   (link_ok_q),
    .ext_i       (ext_fault_i),
    .ext_mask_i  (cfg_o[CFG_W-1 -: EXT_N]),
    .flag_o      (flag_o)
  );

  assign status_o  = {flag_o, comm_q, link_ok_q, fault_q};
  assign wd_trig_o = cfg_o[0];
  assign fail_od_o = flag_o;
endmodule

// File: rtl/gsu_checker.sv
module gsu_checker
  import gsu_pkg::*;
#(
  parameter logic [FLT_N-1:0] FEAT_EN = 5'b11011
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLT_N-1:0]  fault_i,
  input logic              comm_err_i,
  input logic              frame_ok_i,
  input logic              clr_i,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [STAT_W-1:0] status_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic              fail_od_o
);
  assert_comm_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comm_err_i |=> status_o[BIT_COMM] && !status_o[BIT_LINK]);

  assert_frame_links_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_i && !comm_err_i |=> status_o[BIT_LINK] && !status_o[BIT_COMM]);

  assert_fault_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(fault_i & FEAT_EN) |=>
      ((status_o[FLT_N-1:0] & $past(fault_i & FEAT_EN)) == $past(fault_i & FEAT_EN)));

  assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_o[FLT_N-1:0] & $past(status_o[FLT_N-1:0])) == $past(status_o[FLT_N-1:0])));

  assert_cfg_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_o == $past(cfg_wdata_i));

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_o));

  assert_unlinked_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[BIT_LINK] |-> status_o[BIT_FLAG]);

  assert_failsafe_pulls_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> fail_od_o);
endmodule

bind glob_status_unit gsu_checker #(.FEAT_EN(FEAT_EN)) i_gsu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_i    (fault_i),
  .comm_err_i (comm_err_i),
  .frame_ok_i (frame_ok_i),
  .clr_i      (clr_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .status_o   (status_o),
  .cfg_o      (cfg_o),
  .fail_od_o  (fail_od_o)
);

// File: tb/test_glob_status_unit.sv
module test_glob_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] FEAT = 5'b11011;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] fault_i = '0;
  logic [3:0] ext_fault_i = '0;
  logic       comm_err_i = 1'b0, frame_ok_i = 1'b0, clr_i = 1'b0, cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] status_o, cfg_o;
  logic       wd_trig_o, flag_o, fail_od_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [4:0] m_stk = '0;
  logic       m_comm = 1'b0, m_ok = 1'b0;
  logic [7:0] m_cfg = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  glob_status_unit i_glob_status_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .ext_fault_i(ext_fault_i),
    .comm_err_i(comm_err_i), .frame_ok_i(frame_ok_i), .clr_i(clr_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .status_o(status_o),
    .cfg_o(cfg_o), .wd_trig_o(wd_trig_o), .flag_o(flag_o), .fail_od_o(fail_od_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_flag();
    return m_stk[0] | m_stk[4] | (|(m_stk[3:1] & ~m_cfg[3:1])) | m_comm | ~m_ok
         | (|(ext_fault_i & ~m_cfg[7:4]));
  endfunction

  task automatic compare_all();
    logic f;
    f = m_flag();
    chk({3'b0, status_o[4:0]}, {3'b0, m_stk}, "R2 fault bits");
    chk({7'b0, status_o[5]}, {7'b0, m_ok}, "R5 link bit");
    chk({7'b0, status_o[6]}, {7'b0, m_comm}, "R6 comm bit");
    chk({7'b0, status_o[7]}, {7'b0, f}, "R7 flag bit");
    chk({7'b0, flag_o}, {7'b0, f}, "R7 flag_o");
    chk({7'b0, fail_od_o}, {7'b0, f}, "R11 fail_od_o");
    chk(cfg_o, m_cfg, "R10 cfg");
    chk({7'b0, wd_trig_o}, {7'b0, m_cfg[0]}, "R10 wd_trig_o");
  endtask

  task automatic tick();
    @(posedge clk_i);
    m_stk  = (fault_i & FEAT) | (m_stk & ~{5{clr_i}});
    if (comm_err_i) m_comm = 1'b1; else if (frame_ok_i || clr_i) m_comm = 1'b0;
    if (comm_err_i) m_ok = 1'b0; else if (frame_ok_i) m_ok = 1'b1;
    if (cfg_we_i) m_cfg = cfg_wdata_i;
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic pulse_clear();
    clr_i = 1'b1; tick(); clr_i = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v; tick(); cfg_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(status_o, 8'h80, "R1 status after reset");
    chk(cfg_o, 8'h00, "R1 cfg after reset");
    chk({7'b0, fail_od_o}, 8'h01, "R1 fail_od after reset");
    tick();
    frame_ok_i = 1'b1; tick(); frame_ok_i = 1'b0;
    chk(status_o, 8'h20, "R5 link set by valid frame");
    fault_i = 5'b00001; tick(); fault_i = '0;
    chk(status_o, 8'hA1, "R2 fail-safe latched");
    tick();
    chk(status_o, 8'hA1, "R3 sticky after input drop");
    pulse_clear();
    chk(status_o, 8'h20, "R3 cleared by clr");
    fault_i = 5'b00100; tick(); fault_i = '0;
    chk(status_o, 8'h20, "R4 absent feature reads 0");
    fault_i = 5'b01000; tick();
    chk(status_o, 8'hA8, "R2 pre-warning bit 3");
    pulse_clear();
    chk(status_o, 8'hA8, "R3 clear with input held");
    write_cfg(8'h08);
    chk(status_o, 8'h28, "R8 masked bit still shown, flag low");
    chk({7'b0, fail_od_o}, 8'h00, "R11 released when flag low");
    fault_i = '0; pulse_clear();
    chk(status_o, 8'h20, "R3 cleared after drop");
    chk(cfg_o, 8'h08, "R10 clr leaves cfg");
    ext_fault_i = 4'b0010; tick();
    chk(status_o, 8'hA0, "R9 external fault raises flag");
    write_cfg(8'h28);
    chk(status_o, 8'h20, "R9 external fault masked");
    ext_fault_i = '0;
    comm_err_i = 1'b1; tick(); comm_err_i = 1'b0;
    chk(status_o, 8'hC0, "R6 comm error set");
    frame_ok_i = 1'b1; tick(); frame_ok_i = 1'b0;
    chk(status_o, 8'h20, "R6 comm error cleared by frame");
    comm_err_i = 1'b1; frame_ok_i = 1'b1; tick(); comm_err_i = 1'b0; frame_ok_i = 1'b0;
    chk(status_o, 8'hC0, "R6 set wins over clear");
    pulse_clear();
    chk(status_o, 8'h80, "R5 clr leaves link low");
    frame_ok_i = 1'b1; tick(); frame_ok_i = 1'b0;
    write_cfg(8'h01);
    chk({7'b0, wd_trig_o}, 8'h01, "R10 watchdog trigger bit");
    fault_i = 5'b10000; tick(); fault_i = '0;
    chk(status_o, 8'hB0, "R2 thermal bit 4 unmaskable");
    pulse_clear();
    for (int i = 0; i < 400; i++) begin
      fault_i     = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'b0;
      ext_fault_i = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
      comm_err_i  = ($urandom_range(0, 15) == 0);
      frame_ok_i  = ($urandom_range(0, 3) == 0);
      clr_i       = ($urandom_range(0, 7) == 0);
      cfg_we_i    = ($urandom_range(0, 9) == 0);
      cfg_wdata_i = 8'($urandom);
      tick();
    end
    fault_i = '0; ext_fault_i = '0; comm_err_i = 0; frame_ok_i = 0; clr_i = 0; cfg_we_i = 0;
    tick();
    finish_run();
  end
endmodule